// File: doc/BRIEF.md
# Keyed-Clear Watchdog Reset Timer

This block guards a small 8-bit microcontroller against runaway or stalled firmware. A timeout counter runs from its own free-running watchdog clock, separate from the CPU bus clock, so it keeps counting even when the main oscillator has stopped. If the count reaches the terminal value, the block raises a system reset. The reset stays high for a fixed number of watchdog clocks, then drops, and counting starts again from zero.

Firmware services the timer by writing the key byte 0x55 to the write-only service address 0x0020 on the plain CPU bus, which has an address, a write strobe and 8 bits of data. Any other data at that address, or any write to another address, has no effect. No register or pin can stop the timer.

A matching write flips a toggle flop in the bus clock domain. The watchdog domain passes that toggle through two synchronizer flops and detects the change, so one write becomes exactly one clear pulse there. All pins are plain control pins, and there is no streaming interface.

Top module: `keyed_wdt`

## Requirements
- R1: After `wdt_rst_n` is released, `sys_rst` is low and the count starts from zero.
- R2: With no valid service write, `sys_rst` rises on the TERMINAL-th rising edge of `wdt_clk` after the count last started from zero. TERMINAL = WDT_CLK_HZ * TIMEOUT_MS / 1000.
- R3: Once raised, `sys_rst` stays high for exactly RST_HOLD rising edges of `wdt_clk`, then falls.
- R4: When `sys_rst` falls, counting restarts from zero, and the next timeout comes TERMINAL edges after the edge on which it fell.
- R5: A bus write with `bus_we`=1, `bus_addr`=0x0020 and `bus_wdata`=0x55 clears the count. Servicing more often than TERMINAL edges keeps `sys_rst` low for as long as the writes continue. The timer cannot be disabled.
- R6: A write to 0x0020 with any data other than 0x55 (for example 0x54, 0x56, 0xAA or 0x00) is ignored, and the timeout edge is unchanged.
- R7: Writes of 0x55 to any other address are ignored, and so is the key at 0x0020 while `bus_we`=0.
- R8: The count advances, and the timeout occurs on time, while `bus_clk` is stopped.
- R9: A valid service write takes effect within 4 `wdt_clk` edges. The next timeout then falls between K+TERMINAL and K+TERMINAL+5 edges, where K is the edge count at which the write was issued.
- R10: A service write issued while `sys_rst` is high is dropped. The hold still lasts RST_HOLD edges, and the following period is exactly TERMINAL edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | CPU bus clock |
| bus_rst_n | input | 1 | Active-low reset for the bus-side toggle |
| bus_we | input | 1 | Write strobe, sampled on `bus_clk` |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data |
| wdt_clk | input | 1 | Free-running watchdog clock |
| wdt_rst_n | input | 1 | Active-low power-on reset for the watchdog domain |
| sys_rst | output | 1 | Active-high system reset request |

## Verification
The bench sets WDT_CLK_HZ=200 and TIMEOUT_MS=500, which gives a terminal count of 100 watchdog edges. It sets RST_HOLD=8. With these values, many full timeout-and-hold cycles fit in a short run, so every period and hold width can be checked to the exact edge. The two clocks are 20 ns and 30 ns and unrelated, so service writes cross the domain boundary at varying phases. The hold is long enough that a write issued at its start lands inside it.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  parameter int unsigned SVC_ADDR_VAL = 32'h0020;
  parameter logic [7:0]  SVC_KEY      = 8'h55;
endpackage

// File: rtl/wdt_svc_capture.sv
`timescale 1ns/1ps
module wdt_svc_capture #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              req_tgl
);
  import wdt_pkg::*;

  localparam logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(SVC_ADDR_VAL);

  logic hit;
  assign hit = we && (addr == SVC_ADDR) && (wdata == SVC_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   req_tgl <= 1'b0;
    else if (hit) req_tgl <= ~req_tgl;
  end

  AST_KEY_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == SVC_ADDR && wdata == SVC_KEY) |=> (req_tgl != $past(req_tgl))); // R5
  AST_NONKEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == SVC_ADDR && wdata == SVC_KEY) |=> $stable(req_tgl)); // R6
endmodule

// File: rtl/wdt_tgl_sync.sv
`timescale 1ns/1ps
module wdt_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], tgl_in};
      last  <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] ^ last;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (last == $past(chain[STAGES-1]))); // R9
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core #(
  parameter int TERMINAL = 16000,
  parameter int RST_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic rst_out
);
  localparam int CNT_W  = (TERMINAL > 2) ? $clog2(TERMINAL) : 1;
  localparam int HOLD_W = $clog2(RST_HOLD) + 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(TERMINAL - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);

  logic [CNT_W-1:0]  cnt;
  logic [HOLD_W-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hold    <= '0;
      rst_out <= 1'b0;
    end else if (rst_out) begin
      cnt <= '0;
      if (hold == HOLD_LAST) begin
        rst_out <= 1'b0;
        hold    <= '0;
      end else begin
        hold <= hold + 1'b1;
      end
    end else if (clr) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      rst_out <= 1'b1;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_RISE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> ($past(cnt) == CNT_LAST)); // R2
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST); // R2
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> (hold <= HOLD_LAST)); // R3
  AST_ZERO_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> (cnt == '0)); // R4
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rst_out) |=> (cnt == '0 && !rst_out)); // R5
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt #(
  parameter int WDT_CLK_HZ = 32000,
  parameter int TIMEOUT_MS = 500,
  parameter int RST_HOLD   = 16,
  parameter int ADDR_W     = 16
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              wdt_clk,
  input  logic              wdt_rst_n,
  output logic              sys_rst
);
  localparam int TERMINAL = WDT_CLK_HZ * TIMEOUT_MS / 1000;

  logic req_tgl;
  logic clr_pulse;

  wdt_svc_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(bus_clk), .rst_n(bus_rst_n), .we(bus_we),
    .addr(bus_addr), .wdata(bus_wdata), .req_tgl(req_tgl)
  );

  wdt_tgl_sync #(.STAGES(2)) u_sync (
    .clk(wdt_clk), .rst_n(wdt_rst_n), .tgl_in(req_tgl), .pulse(clr_pulse)
  );

  wdt_core #(.TERMINAL(TERMINAL), .RST_HOLD(RST_HOLD)) u_core (
    .clk(wdt_clk), .rst_n(wdt_rst_n), .clr(clr_pulse), .rst_out(sys_rst)
  );

  AST_RESET_LOW: assert property (@(posedge wdt_clk)
    !wdt_rst_n |=> !sys_rst); // R1
endmodule

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/1ps
module keyed_wdt_bench;
  localparam int TERM = 100;
  localparam int HOLD = 8;

  logic bus_clk = 0, wdt_clk = 0, bus_clk_en = 1;
  logic bus_rst_n = 0, wdt_rst_n = 0, bus_we = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic sys_rst;
  int checks = 0, errors = 0, edge_ctr = 0;
  bit done = 0;

  keyed_wdt #(.WDT_CLK_HZ(200), .TIMEOUT_MS(500), .RST_HOLD(HOLD), .ADDR_W(16)) u_keyed_wdt (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wdt_clk(wdt_clk), .wdt_rst_n(wdt_rst_n), .sys_rst(sys_rst)
  );

  always begin #10; if (bus_clk_en) bus_clk = ~bus_clk; end
  always #15 wdt_clk = ~wdt_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic we);
    @(negedge bus_clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_we = 0;
  endtask

  task automatic to_rise(output int n);
    edge_ctr = 0;
    do begin
      @(posedge wdt_clk); #1;
      edge_ctr++;
    end while (!sys_rst && edge_ctr < 4 * TERM);
    n = edge_ctr;
  endtask

  task automatic hold_len(output int n);
    n = 0;
    do begin
      @(posedge wdt_clk); #1;
      n++;
    end while (sys_rst && n < 4 * HOLD);
  endtask

  task automatic period(input int lo, input int hi, input string req);
    int n, h;
    to_rise(n);
    chk(n >= lo && n <= hi, req, n, lo);
    hold_len(h);
    chk(h == HOLD, "R3", h, HOLD);
  endtask

  task automatic t_reset_state();
    chk(sys_rst == 0, "R1", sys_rst, 0);
    @(negedge wdt_clk); wdt_rst_n = 1;
    chk(sys_rst == 0, "R1", sys_rst, 0);
  endtask

  task automatic t_first_timeout();
    period(TERM, TERM, "R2");
  endtask

  task automatic t_restart();
    period(TERM, TERM, "R4");
  endtask

  task automatic t_bad_data();
    fork
      period(TERM, TERM, "R6");
      begin
        wait (edge_ctr >= 10); bus_write(16'h0020, 8'h54, 1);
        wait (edge_ctr >= 30); bus_write(16'h0020, 8'hAA, 1);
        wait (edge_ctr >= 50); bus_write(16'h0020, 8'h56, 1);
        wait (edge_ctr >= 70); bus_write(16'h0020, 8'h00, 1);
      end
    join
  endtask

  task automatic t_bad_addr();
    fork
      period(TERM, TERM, "R7");
      begin
        wait (edge_ctr >= 10); bus_write(16'h0021, 8'h55, 1);
        wait (edge_ctr >= 30); bus_write(16'h0120, 8'h55, 1);
        wait (edge_ctr >= 50); bus_write(16'h0000, 8'h55, 1);
        wait (edge_ctr >= 70); bus_write(16'h0020, 8'h55, 0);
      end
    join
  endtask

  task automatic t_latency();
    fork
      period(40 + TERM, 40 + TERM + 5, "R9");
      begin wait (edge_ctr >= 40); bus_write(16'h0020, 8'h55, 1); end
    join
  endtask

  task automatic t_service();
    int seen = 0;
    for (int k = 0; k < 14; k++) begin
      bus_write(16'h0020, 8'h55, 1);
      repeat (30) begin
        @(posedge wdt_clk); #1;
        if (sys_rst) seen++;
      end
    end
    chk(seen == 0, "R5", seen, 0);
    period(TERM - 30, TERM + 5, "R5");
  endtask

  task automatic t_bus_stopped();
    bus_clk_en = 0;
    period(TERM, TERM, "R8");
    bus_clk_en = 1;
  endtask

  task automatic t_clear_in_hold();
    int n, h;
    to_rise(n);
    chk(n == TERM, "R10", n, TERM);
    fork
      hold_len(h);
      bus_write(16'h0020, 8'h55, 1);
    join
    chk(h == HOLD, "R10", h, HOLD);
    period(TERM, TERM, "R10");
  endtask

  initial begin
    #100; bus_rst_n = 1;
    t_reset_state();
    t_first_timeout();
    t_restart();
    t_bad_data();
    t_bad_addr();
    t_latency();
    t_service();
    t_bus_stopped();
    t_clear_in_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #3000000; errors++; $display("FAIL watchdog timeout"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule